// File: doc/BRIEF.md
# Output Impedance Step Controller

This block keeps a 5-bit drive-strength code for an output driver with 32 binary-weighted levels. An external comparison outside the block supplies an up, down or hold request. The controller looks at that request only on evaluation cycles, which come once every fixed interval (64 cycles by default). On each evaluation it moves its tracking code by at most one level, and it never wraps past either end of the scale.

The tracking code does not reach the driver at once. A separate driver-setting register loads it only on a clock edge where the output is in high impedance. The output is in high impedance when a write or deselect cycle floats the bus, or when the output enable is held inactive around the edge. This keeps the driver from changing strength while it is driving the line.

The block also counts a power-up settling period of 4096 cycles by default. A sticky `calibrated_o` flag rises on the first entry into high impedance, coming from low impedance, after that period has run out.

Top module: `zq_step_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the tracking code and the driver code are set to mid-scale (16) and `calibrated_o` is cleared.
- R2: The request is sampled only on evaluation edges. The first evaluation edge is the 64th edge after reset is released, and the next ones follow every 64 edges. Requests present on other edges have no effect on the tracking code.
- R3: The request is encoded on `cmp_req_i` as 2'b01 = step up, 2'b10 = step down, and 2'b00 or 2'b11 = hold. A hold leaves the tracking code unchanged.
- R4: A step up moves the code by exactly +1. At 31 it saturates and does not wrap to 0.
- R5: A step down moves the code by exactly -1. At 0 it saturates and does not wrap to 31.
- R6: `drive_code_o` loads the value that `track_code_o` held just before an edge, but only on an edge where the output is in high impedance (`bus_hiz_i` or `oe_n_i` is high). On every other edge it holds its value.
- R7: A write or deselect cycle, shown by `bus_hiz_i` = 1, opens an update window on its own.
- R8: An inactive output enable, `oe_n_i` = 1, opens an update window on its own.
- R9: `calibrated_o` stays low for the first 4096 edges after reset is released. It rises on the first later edge that is high impedance when the edge before it was low impedance, and it stays high until the next reset.
- R10: High impedance held without a break from reset onward is not a transition. A low-impedance edge must come before the entry that sets `calibrated_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_req_i | input | 2 | Up/down/hold request from the external comparison |
| bus_hiz_i | input | 1 | Write or deselect cycle: output floated this edge |
| oe_n_i | input | 1 | Output enable, active low, sampled at the edge |
| track_code_o | output | 5 | Internal tracking code |
| drive_code_o | output | 5 | Code applied to the output driver |
| calibrated_o | output | 1 | Settling period over and a high-impedance entry seen |

## Verification
The calibrated flag is the hardest thing to reach. It needs more than 4096 edges since reset, followed by a low-to-high impedance change, and earlier high-impedance pulses must not set it. The stimulus reaches it by running the whole saturation sweep first, with floating pulses mixed in, so that all of that happens inside the settling period. It then stays driven past the 4096th edge and opens one output-enable window. A second reset then holds the bus floating through the whole period, which shows that only a real transition counts.

// File: rtl/zqs_pkg.sv
package zqs_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLDX = 2'b11
  } step_req_e;
endpackage

// File: rtl/zqs_eval_timer.sv
module zqs_eval_timer #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  output logic eval_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam bit POW2 = ((PERIOD & (PERIOD - 1)) == 0);

  logic [CW-1:0] cnt_q;

  generate
    if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  assign eval_o = (cnt_q == LAST);
endmodule

// File: rtl/zqs_code_stepper.sv
module zqs_code_stepper
  import zqs_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int RESET_CODE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic [1:0]        req_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] code_q;
  step_req_e         req;

  assign req = step_req_e'(req_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= INIT;
    end else if (eval_i) begin
      case (req)
        STEP_UP:   if (code_q != TOP) code_q <= code_q + 1'b1;
        STEP_DOWN: if (code_q != '0)  code_q <= code_q - 1'b1;
        default:   code_q <= code_q;
      endcase
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/zqs_settle_tracker.sv
module zqs_settle_tracker #(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic hiz_i,
  output logic calibrated_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] DONE = SW'(SETTLE_CYCLES);

  logic [SW-1:0] cnt_q;
  logic          hiz_q;
  logic          cal_q;
  logic          settled;
  logic          entry;

  assign settled = (cnt_q == DONE);
  assign entry   = hiz_i && !hiz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hiz_q <= 1'b1;
      cal_q <= 1'b0;
    end else begin
      if (!settled)         cnt_q <= cnt_q + 1'b1;
      hiz_q <= hiz_i;
      if (settled && entry) cal_q <= 1'b1;
    end
  end

  assign calibrated_o = cal_q;
endmodule

// File: rtl/zq_step_ctrl.sv
module zq_step_ctrl #(
  parameter int CODE_W        = 5,
  parameter int RESET_CODE    = 16,
  parameter int EVAL_PERIOD   = 64,
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmp_req_i,
  input  logic              bus_hiz_i,
  input  logic              oe_n_i,
  output logic [CODE_W-1:0] track_code_o,
  output logic [CODE_W-1:0] drive_code_o,
  output logic              calibrated_o
);
  localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

  logic              eval;
  logic              hiz_now;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] drv_q;

  assign hiz_now = bus_hiz_i | oe_n_i;

  zqs_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .eval_o (eval)
  );

  zqs_code_stepper #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_step (
    .clk    (clk),
    .rst    (rst),
    .eval_i (eval),
    .req_i  (cmp_req_i),
    .code_o (code)
  );

  zqs_settle_tracker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk          (clk),
    .rst          (rst),
    .hiz_i        (hiz_now),
    .calibrated_o (calibrated_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          drv_q <= INIT;
    else if (hiz_now) drv_q <= code;
  end

  assign track_code_o = code;
  assign drive_code_o = drv_q;
endmodule

// File: rtl/zqs_chk.sv
module zqs_chk #(
  parameter int CODE_W        = 5,
  parameter int EVAL_PERIOD   = 64,
  parameter int SETTLE_CYCLES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmp_req_i,
  input logic              bus_hiz_i,
  input logic              oe_n_i,
  input logic [CODE_W-1:0] track_code_o,
  input logic [CODE_W-1:0] drive_code_o,
  input logic              calibrated_o
);
  localparam int EW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam int SW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic [EW-1:0] phase_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      since_q <= '0;
    end else begin
      phase_q <= (phase_q == EW'(EVAL_PERIOD - 1)) ? '0 : phase_q + 1'b1;
      if (since_q <= SW'(SETTLE_CYCLES)) since_q <= since_q + 1'b1;
    end
  end

  // R2
  eval_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(track_code_o) |-> (phase_q == '0));

  // R3
  hold_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_req_i == 2'b00 || cmp_req_i == 2'b11) |=> $stable(track_code_o));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(track_code_o) |->
      (track_code_o == $past(track_code_o) + 1'b1) ||
      (track_code_o == $past(track_code_o) - 1'b1));

  // R4
  top_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (track_code_o == TOP && cmp_req_i == 2'b01) |=> (track_code_o == TOP));

  // R5
  floor_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (track_code_o == '0 && cmp_req_i == 2'b10) |=> (track_code_o == '0));

  // R6
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive_code_o) |-> $past(bus_hiz_i || oe_n_i));

  // R9
  cal_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(calibrated_o) |-> (since_q > SW'(SETTLE_CYCLES)));

  // R9
  cal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    calibrated_o |=> calibrated_o);
endmodule

bind zq_step_ctrl zqs_chk #(
  .CODE_W        (CODE_W),
  .EVAL_PERIOD   (EVAL_PERIOD),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmp_req_i    (cmp_req_i),
  .bus_hiz_i    (bus_hiz_i),
  .oe_n_i       (oe_n_i),
  .track_code_o (track_code_o),
  .drive_code_o (drive_code_o),
  .calibrated_o (calibrated_o)
);

// File: tb/zq_step_ctrl_tb.sv
module zq_step_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EVAL       = 64;
  localparam int SETTLE     = 4096;
  localparam int MIDSCALE   = 16;

  typedef struct {
    string tag;
    int    trk;
    int    drv;
    int    cal;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmp_req = 2'b00;
  logic       bus_hiz = 1'b0;
  logic       oe_n = 1'b0;
  logic [4:0] track_code;
  logic [4:0] drive_code;
  logic       calibrated;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t q[$];

  int m_ev, m_code, m_drv, m_hizq, m_settle, m_cal;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_step_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .cmp_req_i    (cmp_req),
    .bus_hiz_i    (bus_hiz),
    .oe_n_i       (oe_n),
    .track_code_o (track_code),
    .drive_code_o (drive_code),
    .calibrated_o (calibrated)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected behaviour per edge, written from R1..R10
  task automatic model_edge(input logic r, input logic [1:0] rq, input logic bh, input logic oe);
    int hz;
    if (r) begin
      m_ev = 0; m_code = MIDSCALE; m_drv = MIDSCALE;
      m_hizq = 1; m_settle = 0; m_cal = 0;
    end else begin
      hz = (bh || oe) ? 1 : 0;
      if (hz == 1) m_drv = m_code;
      if (m_ev == EVAL - 1) begin
        if (rq == 2'b01 && m_code < 31) m_code++;
        else if (rq == 2'b10 && m_code > 0) m_code--;
      end
      m_ev = (m_ev + 1) % EVAL;
      if (m_settle == SETTLE && hz == 1 && m_hizq == 0) m_cal = 1;
      if (m_settle < SETTLE) m_settle++;
      m_hizq = hz;
    end
  endtask

  // Driver: applies one edge of stimulus and pushes the expected outputs
  task automatic drive(input logic [1:0] rq, input logic bh, input logic oe, input string tag);
    exp_t e;
    cmp_req = rq; bus_hiz = bh; oe_n = oe;
    @(posedge clk);
    model_edge(rst, rq, bh, oe);
    e.tag = tag; e.trk = m_code; e.drv = m_drv; e.cal = m_cal;
    q.push_back(e);
    #1;
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) drive(2'b00, 1'b0, 1'b0, "R1 reset");
    rst = 1'b0;
  endtask

  // Monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " track"}, int'(track_code), e.trk);
        check({e.tag, " drive"}, int'(drive_code), e.drv);
        check({e.tag, " calibrated"}, int'(calibrated), e.cal);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    apply_reset();
    check("R1 track after reset", int'(track_code), 16);
    check("R1 drive after reset", int'(drive_code), 16);
    check("R1 calibrated after reset", int'(calibrated), 0);

    repeat (EVAL) drive(2'b01, 1'b0, 1'b0, "R2 R6 first evaluation low-Z");
    check("R2 track at first evaluation", int'(track_code), 17);
    check("R6 drive held in low-Z", int'(drive_code), 16);

    for (int i = 0; i < EVAL; i++) begin
      if (m_ev == EVAL - 1) drive(2'b01, 1'b0, 1'b0, "R2 evaluation edge");
      else                  drive(2'b10, 1'b0, 1'b0, "R2 off-evaluation ignored");
    end
    check("R2 off-evaluation requests ignored", int'(track_code), 18);

    drive(2'b00, 1'b1, 1'b0, "R7 write/deselect window");
    check("R7 drive loaded by bus high-Z", int'(drive_code), 18);

    repeat (EVAL) drive(2'b01, 1'b0, 1'b0, "R6 held in low-Z");
    check("R6 drive unchanged in low-Z", int'(drive_code), 18);
    drive(2'b00, 1'b0, 1'b1, "R8 output enable window");
    check("R8 drive loaded by output enable", int'(drive_code), 19);

    repeat (EVAL * 14) drive(2'b01, 1'b0, 1'b0, "R4 step up to ceiling");
    check("R4 saturated at 31", int'(track_code), 31);

    repeat (EVAL * 2) drive(2'b00, 1'b0, 1'b0, "R3 hold 00");
    repeat (EVAL * 2) drive(2'b11, 1'b0, 1'b0, "R3 hold 11");
    check("R3 hold keeps code", int'(track_code), 31);

    for (int i = 0; i < EVAL * 33; i++)
      drive(2'b10, (i % 100) == 50, 1'b0, "R5 step down to floor");
    check("R5 saturated at 0", int'(track_code), 0);
    drive(2'b10, 1'b1, 1'b0, "R5 R7 floor to driver");
    check("R5 drive follows floor", int'(drive_code), 0);
    check("R9 no flag inside settle period", int'(calibrated), 0);

    while (m_settle < SETTLE) drive(2'b00, 1'b0, 1'b0, "R9 settling low-Z");
    repeat (3) drive(2'b00, 1'b0, 1'b0, "R9 settled low-Z");
    check("R9 flag waits for high-Z entry", int'(calibrated), 0);
    drive(2'b00, 1'b0, 1'b1, "R9 first entry after settle");
    check("R9 flag on entry", int'(calibrated), 1);
    repeat (5) drive(2'b00, 1'b0, 1'b0, "R9 sticky low-Z");
    drive(2'b00, 1'b1, 1'b0, "R9 sticky high-Z");
    check("R9 flag sticky", int'(calibrated), 1);

    apply_reset();
    check("R1 flag cleared by reset", int'(calibrated), 0);
    repeat (SETTLE + 100) drive(2'b00, 1'b1, 1'b0, "R10 continuous high-Z");
    check("R10 no transition no flag", int'(calibrated), 0);
    drive(2'b00, 1'b0, 1'b0, "R10 low-Z gap");
    drive(2'b00, 1'b1, 1'b0, "R10 real entry");
    check("R10 flag after real entry", int'(calibrated), 1);

    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule